// File: doc/BRIEF.md
# 64b/65b to 256b/257b Block Transcoder with Reverse Mapper

This block packs four consecutive 65-bit line blocks into one 257-bit word, and it also unpacks such words back into four 65-bit blocks. Each 65-bit block has a one-bit header in bit 0 and a 64-bit payload in bits 64:1. A header of 1 marks a data block and a header of 0 marks a control block. For a control block, the payload's lowest byte (payload bits 7:0) is the type byte.

On the transmit side, blocks arrive on a valid/ready interface. After every fourth accepted block, one 257-bit word is issued with a single-cycle valid. When all four blocks are data, the word is a header bit of 1 followed by the four payloads. When any block is control, the word carries a header bit of 0 and four per-block data/control flags. The 4 bits the flags need are freed by dropping the low nibble of the type byte of the first control block.

The receive side takes 257-bit words with a valid strobe. It rebuilds the four 65-bit blocks one cycle later. The dropped nibble is looked up from the upper nibble of the type byte. Each valid type byte has a distinct upper nibble, so the lookup is exact. An upper nibble that matches no type raises an error flag, and so does a contains-control word whose flags claim four data blocks.

Top module: `xcode_257`

## Requirements
- R1: While reset is asserted (rstN low), inReady, outValid, rxBlkValid and rxErr are all 0.
- R2: From the first clock edge after reset is released, inReady stays 1, and every cycle with inValid high accepts one block.
- R3: outValid is 1 for exactly the one cycle that follows the clock edge accepting the 4th, 8th, 12th… block, and 0 in every other cycle.
- R4: When all four blocks of a group are data, outWord[0] is 1 and outWord[64i+64:64i+1] holds the payload of the i-th block accepted in the group (i = 0..3).
- R5: When any block of a group is control, outWord[0] is 0 and outWord[i+1] equals the header of block i (1 = data, 0 = control).
- R6: In the control case, outWord[256:5] holds the four payloads concatenated in arrival order, lowest bits first, with payload bits 3:0 of the first control block left out.
- R7: Cycles with inValid low add no block to the group and do not shift the positions of the blocks around them.
- R8: A received word with bit 0 equal to 1 yields four data blocks (header 1), with the payload of block i equal to word bits 64i+64:64i+1.
- R9: A received contains-control word restores the dropped nibble from the upper type nibble. The valid types are 1E, 2D, 33, 4B, 55, 66, 78, 87, 99, AA, B4, CC, D2, E1 and FF (hex), and rxErr stays 0 for them.
- R10: rxErr is 1 when a received contains-control word has flags 1111, or when its first control block's upper type nibble matches no valid type (for example 0).
- R11: rxBlkValid is 1 exactly in the cycle after a cycle with rxValid high. rxErr is 0 whenever rxBlkValid is 0.
- R12: A transmitted word fed back into the receive side reproduces the four original 65-bit blocks exactly, with block i at rxBlocks[65i+64:65i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input block present |
| inReady | output | 1 | Transcoder accepts a block this cycle |
| inBlock | input | 65 | Header in bit 0, payload in bits 64:1 |
| outValid | output | 1 | One-cycle strobe for outWord |
| outWord | output | 257 | Packed 257-bit word |
| rxValid | input | 1 | Received word present |
| rxWord | input | 257 | Received 257-bit word |
| rxBlkValid | output | 1 | rxBlocks and rxErr are valid |
| rxBlocks | output | 260 | Four rebuilt 65-bit blocks, block i at bits 65i+64:65i |
| rxErr | output | 1 | Word could not be decoded |

## Verification
The hardest situations to reach from the ports are the receive-side error paths. The transmit side never produces a contains-control word with all flags set, nor one with an unknown type nibble, so a loopback alone never reaches rxErr. The bench places a multiplexer in front of the receive inputs. Most of the time this multiplexer loops the transmitted word straight back. In chosen cycles it substitutes hand-built words: an all-set flag field, an upper nibble of zero, a bare data word, and garbage presented with rxValid low. The transmit side is driven through every valid type byte, with the first control block at each of the four positions and with idle gaps inside the groups.

// File: rtl/xcode_pkg.sv
package xcode_pkg;
  localparam int PAY_W   = 64;
  localparam int NBLK    = 4;
  localparam int NIB     = 4;
  localparam int BLK_W   = PAY_W + 1;
  localparam int P_W     = PAY_W * NBLK;
  localparam int WORD_W  = P_W + 1;
  localparam int SLOT_W  = $clog2(NBLK);
  localparam int PACK_W  = P_W - NIB;

  typedef struct packed {
    logic              capture;
    logic              finish;
    logic [SLOT_W-1:0] slot;
  } xcStrobe_t;

  // index of the lowest cleared flag (first control block); 0 if none
  function automatic logic [SLOT_W-1:0] firstCtl(input logic [NBLK-1:0] flags);
    logic [SLOT_W-1:0] idx;
    idx = '0;
    for (int i = NBLK - 1; i >= 0; i--) begin
      if (!flags[i]) idx = SLOT_W'(i);
    end
    return idx;
  endfunction

  // recovers the low type nibble from the upper one; bit 4 flags a known type
  function automatic logic [NIB:0] lowNibble(input logic [NIB-1:0] up);
    logic [NIB:0] res;
    case (up)
      4'h1: res = {1'b1, 4'hE};
      4'h2: res = {1'b1, 4'hD};
      4'h3: res = {1'b1, 4'h3};
      4'h4: res = {1'b1, 4'hB};
      4'h5: res = {1'b1, 4'h5};
      4'h6: res = {1'b1, 4'h6};
      4'h7: res = {1'b1, 4'h8};
      4'h8: res = {1'b1, 4'h7};
      4'h9: res = {1'b1, 4'h9};
      4'hA: res = {1'b1, 4'hA};
      4'hB: res = {1'b1, 4'h4};
      4'hC: res = {1'b1, 4'hC};
      4'hD: res = {1'b1, 4'h2};
      4'hE: res = {1'b1, 4'h1};
      4'hF: res = {1'b1, 4'hF};
      default: res = '0;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/xcode_ctrl.sv
module xcode_ctrl
  import xcode_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output logic      inReady,
  output xcStrobe_t strb,
  output logic      outValid
);
  logic [SLOT_W-1:0] slotQ;
  logic              rdyQ;
  logic              outVQ;
  logic              accept;

  assign accept       = inValid && rdyQ;
  assign strb.capture = accept;
  assign strb.slot    = slotQ;
  assign strb.finish  = accept && (slotQ == SLOT_W'(NBLK - 1));
  assign inReady      = rdyQ;
  assign outValid     = outVQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ <= '0;
      rdyQ  <= 1'b0;
      outVQ <= 1'b0;
    end else begin
      rdyQ  <= 1'b1;
      outVQ <= strb.finish;
      if (accept) slotQ <= slotQ + 1'b1;
    end
  end

  // R2: once open, the input stays open
  a_r2_ready_holds: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> inReady);
  // R3: a word needs four accepted blocks, so strobes never come back to back
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  // R3: a strobe is only raised by an accepted last block
  a_r3_strobe_cause: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> !outValid);
endmodule

// File: rtl/xcode_dpath.sv
module xcode_dpath
  import xcode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  xcStrobe_t         strb,
  input  logic [BLK_W-1:0]  inBlock,
  output logic [WORD_W-1:0] outWord
);
  logic [BLK_W-1:0]  heldQ [NBLK-1];
  logic [BLK_W-1:0]  blk   [NBLK];
  logic [P_W-1:0]    payAll;
  logic [NBLK-1:0]   flags;
  logic [SLOT_W-1:0] ctlIdx;
  logic [P_W-1:0]    lowMask;
  logic [PACK_W-1:0] packedPay;
  logic [WORD_W-1:0] nextWord;
  logic [WORD_W-1:0] wordQ;

  for (genvar g = 0; g < NBLK - 1; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rstN) heldQ[g] <= '0;
      else if (strb.capture && strb.slot == SLOT_W'(g)) heldQ[g] <= inBlock;
    end
  end

  for (genvar g = 0; g < NBLK; g++) begin : g_split
    if (g < NBLK - 1) begin : g_old
      assign blk[g] = heldQ[g];
    end else begin : g_new
      assign blk[g] = inBlock;
    end
    assign payAll[g*PAY_W +: PAY_W] = blk[g][BLK_W-1:1];
    assign flags[g]                 = blk[g][0];
  end

  always_comb begin
    ctlIdx    = firstCtl(flags);
    lowMask   = ~({P_W{1'b1}} << (PAY_W * int'(ctlIdx)));
    packedPay = PACK_W'((payAll & lowMask) | ((payAll >> NIB) & ~lowMask));
    if (&flags) nextWord = {payAll, 1'b1};
    else        nextWord = {packedPay, flags, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN)            wordQ <= '0;
    else if (strb.finish) wordQ <= nextWord;
  end

  assign outWord = wordQ;

  // R4: the issued word only changes when a group completes
  a_r4_word_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(outWord));
endmodule

// File: rtl/xcode_rev.sv
module xcode_rev
  import xcode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxValid,
  input  logic [WORD_W-1:0]    rxWord,
  output logic                 rxBlkValid,
  output logic [NBLK*BLK_W-1:0] rxBlocks,
  output logic                 rxErr
);
  logic                  hdr;
  logic [NBLK-1:0]       flags;
  logic [SLOT_W-1:0]     ctlIdx;
  logic [P_W-1:0]        packExt;
  logic [P_W-1:0]        lowMask;
  logic [P_W-1:0]        nibMask;
  logic [NIB-1:0]        upNib;
  logic [NIB:0]          look;
  logic [P_W-1:0]        restored;
  logic [P_W-1:0]        payAll;
  logic [NBLK*BLK_W-1:0] blkNext;
  logic                  errNext;
  logic                  vQ;
  logic                  errQ;
  logic [NBLK*BLK_W-1:0] blkQ;

  always_comb begin
    hdr      = rxWord[0];
    flags    = rxWord[NBLK:1];
    ctlIdx   = firstCtl(flags);
    packExt  = {{NIB{1'b0}}, rxWord[WORD_W-1:NBLK+1]};
    lowMask  = ~({P_W{1'b1}} << (PAY_W * int'(ctlIdx)));
    nibMask  = P_W'({NIB{1'b1}}) << (PAY_W * int'(ctlIdx));
    upNib    = NIB'(packExt >> (PAY_W * int'(ctlIdx)));
    look     = lowNibble(upNib);
    restored = (packExt & lowMask)
             | ((packExt << NIB) & ~lowMask & ~nibMask)
             | (P_W'(look[NIB-1:0]) << (PAY_W * int'(ctlIdx)));
    payAll   = hdr ? rxWord[WORD_W-1:1] : restored;
    errNext  = !hdr && ((&flags) || !look[NIB]);
  end

  for (genvar g = 0; g < NBLK; g++) begin : g_join
    assign blkNext[g*BLK_W +: BLK_W] = {payAll[g*PAY_W +: PAY_W], hdr | flags[g]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vQ   <= 1'b0;
      errQ <= 1'b0;
      blkQ <= '0;
    end else begin
      vQ   <= rxValid;
      errQ <= rxValid && errNext;
      if (rxValid) blkQ <= blkNext;
    end
  end

  assign rxBlkValid = vQ;
  assign rxErr      = errQ;
  assign rxBlocks   = blkQ;

  // R11: every received word yields a result one cycle later
  a_r11_latency: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> rxBlkValid);
  // R11: the error flag only accompanies a result
  a_r11_err_qualified: assert property (@(posedge clk) disable iff (!rstN)
    rxErr |-> rxBlkValid);
  // R8: a bare data word can never be flagged
  a_r8_data_clean: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxWord[0]) |=> !rxErr);
endmodule

// File: rtl/xcode_257.sv
module xcode_257
  import xcode_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [BLK_W-1:0]        inBlock,
  output logic                    outValid,
  output logic [WORD_W-1:0]       outWord,
  input  logic                    rxValid,
  input  logic [WORD_W-1:0]       rxWord,
  output logic                    rxBlkValid,
  output logic [NBLK*BLK_W-1:0]   rxBlocks,
  output logic                    rxErr
);
  xcStrobe_t strb;

  xcode_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .strb     (strb),
    .outValid (outValid)
  );

  xcode_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inBlock (inBlock),
    .outWord (outWord)
  );

  xcode_rev u_rev (
    .clk        (clk),
    .rstN       (rstN),
    .rxValid    (rxValid),
    .rxWord     (rxWord),
    .rxBlkValid (rxBlkValid),
    .rxBlocks   (rxBlocks),
    .rxErr      (rxErr)
  );

  // R5: a contains-control word always marks at least one control block
  a_r5_flag_present: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outWord[0]) |-> !(&outWord[NBLK:1]));
  // R1: nothing is issued straight out of reset
  a_r1_quiet_reset: assert property (@(posedge clk)
    !rstN |=> (!outValid && !rxBlkValid && !rxErr));
endmodule

// File: tb/sim_xcode_257.sv
module sim_xcode_257;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [64:0]  inBlock;
  logic         inReady;
  logic         outValid;
  logic [256:0] outWord;
  logic         rxValid;
  logic [256:0] rxWord;
  logic         rxBlkValid;
  logic [259:0] rxBlocks;
  logic         rxErr;

  logic         injMode;
  logic         injValidD;
  logic [256:0] injWordD;

  assign rxValid = injMode ? injValidD : outValid;
  assign rxWord  = injMode ? injWordD  : outWord;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xcode_257 u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inBlock(inBlock),
    .outValid(outValid), .outWord(outWord), .rxValid(rxValid), .rxWord(rxWord),
    .rxBlkValid(rxBlkValid), .rxBlocks(rxBlocks), .rxErr(rxErr)
  );

  int nChk = 0;
  int nFail = 0;

  // reference model state
  int           cnt = 0;
  logic [259:0] grpFlat = '0;
  logic         expOutV = 1'b0;
  logic [259:0] expOutGrp = '0;

  // injection settings for the next step
  logic         injOn = 1'b0;
  logic         injV = 1'b0;
  logic [256:0] injW = '0;
  logic         injErrE = 1'b0;
  logic         injChkBlk = 1'b0;
  logic [259:0] injBlk = '0;

  byte unsigned typeList [15] = '{8'h1E, 8'h2D, 8'h33, 8'h4B, 8'h55, 8'h66, 8'h78,
                                  8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};

  task automatic chk(input string tag, input logic [259:0] act, input logic [259:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [256:0] refWord(input logic [259:0] g);
    logic [256:0] w;
    int k;
    int pos;
    w = '0;
    k = -1;
    for (int i = 0; i < 4; i++) if (!g[65*i] && k < 0) k = i;
    if (k < 0) begin
      w[0] = 1'b1;
      pos = 1;
      for (int i = 0; i < 4; i++)
        for (int b = 0; b < 64; b++) begin w[pos] = g[65*i+1+b]; pos++; end
    end else begin
      w[0] = 1'b0;
      for (int i = 0; i < 4; i++) w[1+i] = g[65*i];
      pos = 5;
      for (int i = 0; i < 4; i++)
        for (int b = 0; b < 64; b++)
          if (!(i == k && b < 4)) begin w[pos] = g[65*i+1+b]; pos++; end
    end
    return w;
  endfunction

  function automatic logic [64:0] dataBlk();
    return {$urandom(), $urandom(), 1'b1};
  endfunction

  function automatic logic [64:0] ctlBlk(input int t);
    logic [55:0] rest;
    rest = {$urandom(), $urandom()};
    return {rest, typeList[t], 1'b0};
  endfunction

  task automatic step(input logic v, input logic [64:0] b);
    logic         rxvIn, rxeExp, rxChk, newV;
    logic [259:0] rxbExp, newGrp;
    logic [256:0] ew;
    inValid   = v;
    inBlock   = b;
    injMode   = injOn;
    injValidD = injV;
    injWordD  = injW;
    if (injOn) begin
      rxvIn = injV; rxeExp = injErrE; rxChk = injChkBlk; rxbExp = injBlk;
    end else begin
      rxvIn = expOutV; rxeExp = 1'b0; rxChk = 1'b1; rxbExp = expOutGrp;
    end
    newV = 1'b0;
    newGrp = expOutGrp;
    if (v) begin
      grpFlat[65*cnt +: 65] = b;
      if (cnt == 3) begin newV = 1'b1; newGrp = grpFlat; end
      cnt = (cnt + 1) % 4;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2", 260'(inReady), 260'(1));
    chk("R3", 260'(outValid), 260'(newV));
    if (newV) begin
      ew = refWord(newGrp);
      if (ew[0]) chk("R4", 260'(outWord), 260'(ew));
      else begin
        chk("R5", 260'(outWord[4:0]), 260'(ew[4:0]));
        chk("R6", 260'(outWord), 260'(ew));
      end
    end
    chk("R11", 260'(rxBlkValid), 260'(rxvIn));
    if (rxvIn) begin
      chk(rxeExp ? "R10" : "R9", 260'(rxErr), 260'(rxeExp));
      if (rxChk) chk(injOn ? "R8" : "R12", rxBlocks, rxbExp);
    end else begin
      chk("R11", 260'(rxErr), 260'(0));
    end
    expOutV   = newV;
    expOutGrp = newGrp;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [64:0] pat [4];
    logic [259:0] db;
    rstN = 1'b0; inValid = 1'b0; inBlock = '0;
    injMode = 1'b0; injValidD = 1'b0; injWordD = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", 260'(inReady), 260'(0));
    chk("R1", 260'(outValid), 260'(0));
    chk("R1", 260'(rxBlkValid), 260'(0));
    chk("R1", 260'(rxErr), 260'(0));
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R2", 260'(inReady), 260'(1));

    // R4: all-data group
    for (int i = 0; i < 4; i++) step(1'b1, dataBlk());
    // R5/R6/R9: each type byte, first control block at each position
    for (int t = 0; t < 15; t++) begin
      for (int i = 0; i < 4; i++) pat[i] = dataBlk();
      pat[t % 4] = ctlBlk(t);
      if (t % 3 == 0) pat[3] = ctlBlk((t + 5) % 15);
      for (int i = 0; i < 4; i++) step(1'b1, pat[i]);
    end
    // all four control
    for (int i = 0; i < 4; i++) step(1'b1, ctlBlk(i * 4));
    // R7: idle gaps inside a group must not shift positions
    step(1'b1, dataBlk()); step(1'b0, '1);
    step(1'b1, ctlBlk(7)); step(1'b0, '0); step(1'b0, '1);
    step(1'b1, dataBlk()); step(1'b0, '1);
    step(1'b1, ctlBlk(2));
    // random mix, back to back with occasional gaps
    for (int n = 0; n < 160; n++) begin
      if ($urandom_range(0, 4) == 0) step(1'b0, {$urandom(), $urandom(), 1'b0});
      if ($urandom_range(0, 1) == 0) step(1'b1, dataBlk());
      else step(1'b1, ctlBlk($urandom_range(0, 14)));
    end
    step(1'b0, '0);
    step(1'b0, '0);

    // injections into the receive side
    injOn = 1'b1;
    // R10: contains-control word with flags 1111
    injV = 1'b1; injW = {{8{$urandom()}}, 1'b1, 4'b1111, 1'b0}; injErrE = 1'b1; injChkBlk = 1'b0;
    step(1'b0, '0);
    // R10: first control block upper type nibble 0
    injW = {{7{$urandom()}}, 20'h00000, 4'h0, 4'b1110, 1'b0};
    injW[8:5] = 4'h0;
    step(1'b0, '0);
    // R10: first control at block 2, its upper nibble (word bits 136:133) is 0
    injW = {{8{$urandom()}}, 1'b1, 4'b1011, 1'b0};
    injW[136:133] = 4'h0;
    step(1'b0, '0);
    // R8: bare data word
    injW = {{8{$urandom()}}, 1'b1};
    for (int i = 0; i < 4; i++) db[65*i +: 65] = {injW[64*i+1 +: 64], 1'b1};
    injBlk = db; injErrE = 1'b0; injChkBlk = 1'b1;
    step(1'b0, '0);
    // R11: garbage with rxValid low gives no result
    injV = 1'b0; injW = {{8{$urandom()}}, 1'b0}; injW[8:5] = 4'h0; injChkBlk = 1'b0;
    step(1'b0, '0);
    step(1'b0, '0);
    injOn = 1'b0; injV = 1'b0;
    step(1'b0, '0);
    summary();
  end
endmodule